// File: doc/BRIEF.md
# Receive Frame Staging Buffer

This block sits between a network receive engine and a larger receive data FIFO that a host reads. The receive engine delivers frame data one word per cycle with start and end markers and cannot be stalled. Words are held in a small local store and move on to the downstream FIFO whenever that FIFO signals room. If the downstream FIFO stays full, words keep piling up in the local store.

When the local store cannot take another word, the frame being received is discarded as a whole. The write pointer falls back to the first word of that frame, so no fragment ever reaches the downstream side. The rest of that frame is ignored. Each later frame is judged again when its start word arrives, and every lost frame adds one to a saturating counter that clears when the host reads it. The fill level of the local store is not visible outside and does not depend on any threshold the host programs for the downstream FIFOs.

Top module: `rx_stage_buf`

## Requirements
- R1: While reset is asserted and after its release, `dn_vld` is low and `host_drops` is zero until a frame is stored or lost.
- R2: Words of a stored frame leave on `dn_*` in arrival order, with `dn_sof` set on the first word and `dn_eof` on the last. A word moves on in a cycle where `dn_vld` and `dn_ready` are both high. While `dn_ready` is low, the presented word and its markers stay unchanged.
- R3: No word of a frame is presented before that frame's end word has been stored. The frame's first word is presented in the cycle after the clock edge that stores its end word, provided no older frame is still waiting.
- R4: While `dn_ready` is low, up to DEPTH words of complete and in-progress frames accumulate without loss.
- R5: If a word of an accepted frame arrives while the store holds DEPTH words, the whole frame is discarded, `host_drops` rises by one, and the frames stored before it are unaffected.
- R6: After a frame is discarded, its remaining words are ignored. The next start word is accepted whenever fewer than DEPTH words are held at its clock edge.
- R7: A start word that arrives while DEPTH words are held is rejected: that frame is lost and counted once.
- R8: Words with `mac_sof` low that arrive when no frame is being accepted are ignored and are not counted.
- R9: A start word that arrives while a frame is still being accepted discards the partial frame, counts it as lost, and begins the new frame.
- R10: `host_drops` saturates at all-ones.
- R11: A cycle with `host_rd` high sets `host_drops` to 0 at the next edge, or to 1 if a frame is lost in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mac_vld | input | 1 | Receive word valid; cannot be stalled |
| mac_data | input | DATA_W | Receive word |
| mac_sof | input | 1 | Word is the first of a frame |
| mac_eof | input | 1 | Word is the last of a frame |
| dn_ready | input | 1 | Downstream FIFO can take a word this cycle |
| dn_vld | output | 1 | A word of a complete frame is presented |
| dn_data | output | DATA_W | Presented word |
| dn_sof | output | 1 | Presented word starts a frame |
| dn_eof | output | 1 | Presented word ends a frame |
| host_rd | input | 1 | Host read of the drop counter; clears it |
| host_drops | output | CNT_W | Count of lost frames |

## Verification
A stale or wrong pointer shows at the downstream port within a cycle or two. A commit pointer that runs ahead of the write side presents a frame before its end word or without its start marker. A rollback that misses leaves a fragment that appears between whole frames. A fill check that is off by one either counts a loss too early or overwrites the word being presented, and the changed data shows during the next stall. The reference model tracks committed and partial words separately and compares valid, data, markers and counter on every clock, so each of these errors surfaces in the cycle it first reaches a port.

// File: rtl/rxsb_pkg.sv
package rxsb_pkg;
   typedef enum logic [1:0] {
      WS_IDLE = 2'd0,
      WS_FILL = 2'd1,
      WS_DROP = 2'd2
   } wstate_e;

   localparam int MARK_W = 2;
endpackage

// File: rtl/rxsb_mem.sv
module rxsb_mem #(
   parameter int WIDTH = 34,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wen,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] ent [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (wen && (waddr == AW'(i))) begin
            ent[i] <= wdata;
         end
      end
   end

   assign rdata = ent[raddr];
endmodule

// File: rtl/rxsb_wr_ctrl.sv
module rxsb_wr_ctrl
   import rxsb_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic          in_sof,
   input  logic          in_eof,
   input  logic [PW-1:0] rd_ptr,
   output logic          wen,
   output logic [AW-1:0] waddr,
   output logic [PW-1:0] wr_ptr,
   output logic [PW-1:0] commit_ptr,
   output logic          lost
);
   localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

   wstate_e       st_q, st_d;
   logic [PW-1:0] wr_d, cm_d;
   logic [PW-1:0] lvl_all, lvl_cm;

   assign lvl_all = wr_ptr - rd_ptr;
   assign lvl_cm  = commit_ptr - rd_ptr;

   always_comb begin
      st_d  = st_q;
      wr_d  = wr_ptr;
      cm_d  = commit_ptr;
      wen   = 1'b0;
      waddr = wr_ptr[AW-1:0];
      lost  = 1'b0;
      if (in_vld) begin
         if (in_sof) begin
            // a frame still open is abandoned; space check starts from commit
            lost  = (st_q == WS_FILL);
            waddr = commit_ptr[AW-1:0];
            if (lvl_cm == FULL_LVL) begin
               lost = 1'b1;
               wr_d = commit_ptr;
               st_d = in_eof ? WS_IDLE : WS_DROP;
            end else begin
               wen  = 1'b1;
               wr_d = commit_ptr + PW'(1);
               if (in_eof) begin
                  cm_d = commit_ptr + PW'(1);
                  st_d = WS_IDLE;
               end else begin
                  st_d = WS_FILL;
               end
            end
         end else if (st_q == WS_FILL) begin
            if (lvl_all == FULL_LVL) begin
               lost = 1'b1;
               wr_d = commit_ptr;
               st_d = in_eof ? WS_IDLE : WS_DROP;
            end else begin
               wen  = 1'b1;
               wr_d = wr_ptr + PW'(1);
               if (in_eof) begin
                  cm_d = wr_ptr + PW'(1);
                  st_d = WS_IDLE;
               end
            end
         end else if ((st_q == WS_DROP) && in_eof) begin
            st_d = WS_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= WS_IDLE;
         wr_ptr     <= '0;
         commit_ptr <= '0;
      end else begin
         st_q       <= st_d;
         wr_ptr     <= wr_d;
         commit_ptr <= cm_d;
      end
   end
endmodule

// File: rtl/rxsb_drop_cnt.sv
module rxsb_drop_cnt #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] count
);
   logic [CNT_W-1:0] nxt;

   if (SATURATE) begin : g_sat
      always_comb begin
         if (clr)                      nxt = inc ? CNT_W'(1) : '0;
         else if (inc && (~&count))    nxt = count + CNT_W'(1);
         else                          nxt = count;
      end
   end else begin : g_wrap
      always_comb begin
         if (clr)      nxt = inc ? CNT_W'(1) : '0;
         else if (inc) nxt = count + CNT_W'(1);
         else          nxt = count;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= nxt;
   end
endmodule

// File: rtl/rx_stage_buf.sv
module rx_stage_buf
   import rxsb_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int DEPTH    = 16,
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1,
   localparam int AW      = $clog2(DEPTH),
   localparam int PW      = AW + 1,
   localparam int EW      = DATA_W + MARK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mac_vld,
   input  logic [DATA_W-1:0] mac_data,
   input  logic              mac_sof,
   input  logic              mac_eof,
   input  logic              dn_ready,
   output logic              dn_vld,
   output logic [DATA_W-1:0] dn_data,
   output logic              dn_sof,
   output logic              dn_eof,
   input  logic              host_rd,
   output logic [CNT_W-1:0]  host_drops
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rx_stage_buf: DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("rx_stage_buf: DATA_W and CNT_W must be positive");
   end

   logic [PW-1:0] rd_ptr, wr_ptr, commit_ptr;
   logic          wen, lost, fire;
   logic [AW-1:0] waddr;
   logic [EW-1:0] rd_word;

   rxsb_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
      .clk(clk), .rst_n(rst_n),
      .in_vld(mac_vld), .in_sof(mac_sof), .in_eof(mac_eof),
      .rd_ptr(rd_ptr), .wen(wen), .waddr(waddr),
      .wr_ptr(wr_ptr), .commit_ptr(commit_ptr), .lost(lost)
   );

   rxsb_mem #(.WIDTH(EW), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .wen(wen), .waddr(waddr),
      .wdata({mac_sof, mac_eof, mac_data}),
      .raddr(rd_ptr[AW-1:0]), .rdata(rd_word)
   );

   rxsb_drop_cnt #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(lost), .clr(host_rd), .count(host_drops)
   );

   assign dn_vld  = (rd_ptr != commit_ptr);
   assign fire    = dn_vld && dn_ready;
   assign dn_sof  = rd_word[EW-1];
   assign dn_eof  = rd_word[EW-2];
   assign dn_data = rd_word[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rd_ptr <= '0;
      else if (fire) rd_ptr <= rd_ptr + PW'(1);
   end
endmodule

// File: rtl/rxsb_chk.sv
module rxsb_chk #(
   parameter int DATA_W   = 32,
   parameter int DEPTH    = 16,
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1,
   localparam int PW      = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mac_vld,
   input logic              mac_sof,
   input logic              dn_ready,
   input logic              dn_vld,
   input logic [DATA_W-1:0] dn_data,
   input logic              dn_sof,
   input logic              dn_eof,
   input logic              host_rd,
   input logic [CNT_W-1:0]  host_drops,
   input logic [PW-1:0]     wr_ptr,
   input logic [PW-1:0]     rd_ptr,
   input logic [PW-1:0]     commit_ptr,
   input logic              lost
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic exp_sof;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 exp_sof <= 1'b1;
      else if (dn_vld && dn_ready) exp_sof <= dn_eof;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ptr - rd_ptr) <= PW'(DEPTH)); // R4
   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      dn_vld && !dn_ready |=> dn_vld && $stable(dn_data) && $stable(dn_sof) && $stable(dn_eof)); // R2
   AST_SOF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      dn_vld && exp_sof |-> dn_sof); // R3
   AST_COMMIT_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_ptr - rd_ptr) <= (wr_ptr - rd_ptr)); // R3
   AST_LOSS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd && lost && host_drops != CMAX |=> host_drops == $past(host_drops) + CNT_W'(1)); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      mac_vld && !mac_sof && (wr_ptr == commit_ptr) |=> $stable(wr_ptr) && $stable(commit_ptr)); // R8
   AST_CLEAR_READ: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd |=> host_drops == CNT_W'($past(lost))); // R11
   if (SATURATE) begin : g_sat_chk
      AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
         host_drops == CMAX && !host_rd |=> host_drops == CMAX); // R10
   end
endmodule

bind rx_stage_buf rxsb_chk #(
   .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .SATURATE(SATURATE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mac_vld(mac_vld), .mac_sof(mac_sof),
   .dn_ready(dn_ready), .dn_vld(dn_vld), .dn_data(dn_data),
   .dn_sof(dn_sof), .dn_eof(dn_eof), .host_rd(host_rd),
   .host_drops(host_drops), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
   .commit_ptr(commit_ptr), .lost(lost)
);

// File: tb/sim_rx_stage_buf.sv
module sim_rx_stage_buf;
   localparam int PERIOD = 10;
   localparam int DW     = 16;
   localparam int DEPTH  = 8;
   localparam int CW     = 4;
   localparam int CMAX   = (1 << CW) - 1;

   typedef struct packed { logic s; logic e; logic [DW-1:0] d; } wd_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mac_vld = 1'b0, mac_sof = 1'b0, mac_eof = 1'b0;
   logic [DW-1:0] mac_data = '0;
   logic          dn_ready = 1'b0, host_rd = 1'b0;
   logic          dn_vld, dn_sof, dn_eof;
   logic [DW-1:0] dn_data;
   logic [CW-1:0] host_drops;

   int    checks = 0, fails = 0;
   bit    ended = 1'b0;
   string tag = "R1";

   wd_t committed[$];
   wd_t partial[$];
   int  mstate = 0; // 0 idle, 1 filling, 2 dropping
   int  mcnt = 0;

   always #(PERIOD/2) clk = ~clk;

   rx_stage_buf #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW), .SATURATE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .mac_vld(mac_vld), .mac_data(mac_data),
      .mac_sof(mac_sof), .mac_eof(mac_eof), .dn_ready(dn_ready),
      .dn_vld(dn_vld), .dn_data(dn_data), .dn_sof(dn_sof), .dn_eof(dn_eof),
      .host_rd(host_rd), .host_drops(host_drops)
   );

   // reference model, updated on every active edge
   always @(posedge clk) begin
      if (!rst_n) begin
         committed.delete(); partial.delete(); mstate = 0; mcnt = 0;
      end else begin
         int  used;
         bit  fire, lst;
         wd_t w;
         used = committed.size() + partial.size();
         fire = (committed.size() > 0) && dn_ready;
         lst  = 1'b0;
         w    = '{s: mac_sof, e: mac_eof, d: mac_data};
         if (mac_vld) begin
            if (mac_sof) begin
               if (mstate == 1) begin
                  lst = 1'b1; used -= partial.size(); partial.delete();
               end
               if (used == DEPTH) begin
                  lst = 1'b1; mstate = mac_eof ? 0 : 2;
               end else if (mac_eof) begin
                  committed.push_back(w); mstate = 0;
               end else begin
                  partial.push_back(w); mstate = 1;
               end
            end else if (mstate == 1) begin
               if (used == DEPTH) begin
                  lst = 1'b1; partial.delete(); mstate = mac_eof ? 0 : 2;
               end else begin
                  partial.push_back(w);
                  if (mac_eof) begin
                     foreach (partial[i]) committed.push_back(partial[i]);
                     partial.delete(); mstate = 0;
                  end
               end
            end else if (mstate == 2 && mac_eof) begin
               mstate = 0;
            end
         end
         if (fire) void'(committed.pop_front());
         if (host_rd)                 mcnt = lst ? 1 : 0;
         else if (lst && mcnt < CMAX) mcnt++;
      end
   end

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // compare away from the active edge
   always @(negedge clk) begin
      if (!ended) begin
         if (!rst_n) begin
            chk(dn_vld == 1'b0, "dn_vld in reset", dn_vld, 0);
            chk(host_drops == '0, "host_drops in reset", host_drops, 0);
         end else begin
            chk(dn_vld == (committed.size() > 0), "dn_vld", dn_vld, committed.size() > 0);
            if (committed.size() > 0 && dn_vld) begin
               chk({dn_sof, dn_eof, dn_data} == committed[0], "dn word",
                   {dn_sof, dn_eof, dn_data}, committed[0]);
            end
            chk(host_drops == CW'(mcnt), "host_drops", host_drops, mcnt);
         end
      end
   end

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   task automatic cyc(input bit v, input bit s, input bit e, input int d);
      @(posedge clk); #1;
      mac_vld = v; mac_sof = s; mac_eof = e; mac_data = DW'(d);
   endtask

   task automatic frame(input int len, input int base);
      for (int i = 0; i < len; i++) cyc(1'b1, i == 0, i == len - 1, base + i);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      tag = "R1";
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle(2);

      tag = "R2"; dn_ready = 1'b1;
      frame(3, 16'h100); frame(1, 16'h110); frame(4, 16'h120); idle(4);

      tag = "R3"; dn_ready = 1'b0;
      frame(3, 16'h200); idle(2); dn_ready = 1'b1; idle(5);

      tag = "R4"; dn_ready = 1'b0;
      frame(4, 16'h300); frame(4, 16'h310); idle(2);

      tag = "R7";
      cyc(1'b1, 1'b1, 1'b0, 16'h320);
      tag = "R6";
      cyc(1'b1, 1'b0, 1'b1, 16'h321);
      dn_ready = 1'b1; idle(3); dn_ready = 1'b0;
      frame(2, 16'h330);

      tag = "R5";
      frame(5, 16'h340); idle(2);
      dn_ready = 1'b1; idle(10);

      tag = "R8";
      cyc(1'b1, 1'b0, 1'b0, 16'h400); cyc(1'b1, 1'b0, 1'b1, 16'h401);
      frame(2, 16'h410); idle(3);

      tag = "R9";
      cyc(1'b1, 1'b1, 1'b0, 16'h500); cyc(1'b1, 1'b0, 1'b0, 16'h501);
      frame(3, 16'h510); idle(4);

      tag = "R10"; dn_ready = 1'b0;
      frame(8, 16'h600);
      for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, 1'b1, 16'h700 + i);
      idle(2);

      tag = "R11";
      host_rd = 1'b1; idle(1); host_rd = 1'b0; idle(1);
      cyc(1'b1, 1'b1, 1'b1, 16'h800); host_rd = 1'b1;
      cyc(1'b1, 1'b1, 1'b1, 16'h801); host_rd = 1'b0;
      idle(2); dn_ready = 1'b1; idle(10);

      tag = "R2";
      for (int i = 0; i < 400; i++) begin
         cyc(($urandom % 4) != 0, ($urandom % 4) == 0, ($urandom % 3) == 0, i);
         dn_ready = ($urandom % 3) == 0;
         host_rd  = ($urandom % 16) == 0;
      end
      mac_vld = 1'b0; host_rd = 1'b0; dn_ready = 1'b1;
      idle(12);
      finish_run();
   end
endmodule